// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block holds the data register of an eight-pin general purpose I/O port and exposes it through a 256-word aliased window in the low part of the port's address space. Within that window, byte-offset bits [9:2] form a per-pin mask, so software can read or change any subset of pins in a single access, with no read-modify-write sequence. A write only touches pins that are both selected by the address mask and configured as outputs. A read returns the register ANDed with the mask.

A direction vector from the port's configuration logic selects, pin by pin, whether the data bit drives the pin or the pin drives the data bit. Output pins present their data bit. Input pins present a constant 1, so they float high. Input levels pass through a two-flop synchroniser before they reach the register. The block also gives a downstream interrupt unit the current register value and a one-cycle per-pin changed-input vector.

Top module: `gpio_masked_port`

## Requirements
- R1: An access whose byte offset is below 0x400 (offset bits [11:10] both 0) targets the data register. The pin mask is offset bits [9:2], where bit 2 selects pin 0. Offset bits [1:0] are ignored.
- R2: A read access (acc_en=1, acc_wr=0) inside the window loads acc_rdata with the data register ANDed with the mask, using the register value before that clock edge. The value appears after that edge. acc_rdata holds its value on every cycle without a read access.
- R3: A write access (acc_en=1, acc_wr=1) inside the window changes only bits whose mask bit is 1 and whose dir_i bit is 1 (output). Those bits take acc_wdata from the next edge on. All other output bits keep their value.
- R4: For each pin i, pin_o[i] equals the data bit when dir_i[i]=1 and equals 1 when dir_i[i]=0.
- R5: For a pin with dir_i=0, a level applied on pin_i before edge k appears in data_o after edge k+2, that is, after three rising edges. For a pin with dir_i=1, pin_i has no effect on its data bit.
- R6: While rst_n is low, data_o, acc_rdata, in_chg_o and the synchroniser flops are all 0. With dir_i=0, pin_o is therefore 0xFF.
- R7: in_chg_o[i] is 1 for exactly one cycle after the edge at which the synchronised level of pin i differs from its value one edge earlier, provided dir_i[i]=0 at that edge. This is the same edge at which data_o takes the new input level.
- R8: An access at byte offset 0x400 or above is outside the window. A write there changes nothing, and a read there loads acc_rdata with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 8 | Per-pin direction, 1 = output |
| pin_i | input | 8 | External pin levels, asynchronous |
| pin_o | output | 8 | Pin drive values |
| acc_en | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset of the access |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Registered read data |
| data_o | output | 8 | Current data register value |
| in_chg_o | output | 8 | One-cycle changed-input pulses |

## Verification
Each result has its own timing:
- Writes and reads show their effect one edge after the access.
- pin_o follows data_o and dir_i with no register in between.
- A level on an input pin reaches data_o and in_chg_o only after the third rising edge.

The bench keeps a reference state that it advances once per rising edge from the inputs applied in that cycle. It compares every output against that state at the falling edge that follows, so each result is sampled exactly when it is due. A few directed checks repeat this comparison for the mask decode, the out-of-window access and the reset values.

// File: rtl/gpio_dp_pkg.sv
package gpio_dp_pkg;

  // Kind of bus access seen in the current cycle.
  typedef enum logic [2:0] {
    ACC_IDLE    = 3'd0,
    ACC_RD_HIT  = 3'd1,
    ACC_WR_HIT  = 3'd2,
    ACC_RD_MISS = 3'd3,
    ACC_WR_MISS = 3'd4
  } acc_kind_e;

  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned MASK_LSB        = 2;

endpackage

// File: rtl/gpio_win_decode.sv
module gpio_win_decode
  import gpio_dp_pkg::*;
#(
  parameter int unsigned NPIN   = 8,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  output acc_kind_e         kind_o,
  output logic [NPIN-1:0]   mask_o
);

  localparam int unsigned MASK_MSB = MASK_LSB + NPIN - 1;

  logic in_win;
  logic addr_unused;

  // Upper offset bits must be zero to land in the aliased window (R1, R8).
  generate
    if (ADDR_W > MASK_MSB + 1) begin : g_upper
      assign in_win = (acc_addr[ADDR_W-1:MASK_MSB+1] == '0);
    end else begin : g_full
      assign in_win = 1'b1;
    end
  endgenerate

  assign mask_o      = acc_addr[MASK_MSB:MASK_LSB];
  assign addr_unused = ^acc_addr[MASK_LSB-1:0];

  always_comb begin
    kind_o = ACC_IDLE;
    if (acc_en) begin
      if (acc_wr) kind_o = in_win ? ACC_WR_HIT : ACC_WR_MISS;
      else        kind_o = in_win ? ACC_RD_HIT : ACC_RD_MISS;
    end
  end

endmodule

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stage_d[s] = d_i;
      end else begin : g_next
        assign stage_d[s] = stage_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_data_reg.sv
module gpio_data_reg
  import gpio_dp_pkg::*;
#(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  acc_kind_e       kind_i,
  input  logic [NPIN-1:0] mask_i,
  input  logic [NPIN-1:0] wdata_i,
  input  logic [NPIN-1:0] dir_i,
  input  logic [NPIN-1:0] smp_i,
  output logic [NPIN-1:0] data_q
);

  logic            wr_hit;
  logic [NPIN-1:0] data_d;
  logic [NPIN-1:0] ld_en;

  assign wr_hit = (kind_i == ACC_WR_HIT);

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_bit
      // Input pins load the sampled level every cycle.
      // Output pins load only on a masked write.
      always_comb begin
        ld_en[i]  = !dir_i[i] || (wr_hit && mask_i[i]);
        data_d[i] = dir_i[i] ? wdata_i[i] : smp_i[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        data_q[i] <= 1'b0;
        else if (ld_en[i]) data_q[i] <= data_d[i];
      end
    end
  endgenerate

  // R3: output bits move only where a window write selected them
  a_r3_write_scope: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((data_q ^ $past(data_q)) & $past(dir_i) &
                ~($past(wr_hit) ? $past(mask_i) : '0)) == '0));

  // R5: input bits follow the synchronised level one edge later
  a_r5_input_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((data_q & ~$past(dir_i)) == ($past(smp_i) & ~$past(dir_i))));

endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] smp_i,
  input  logic [NPIN-1:0] dir_i,
  output logic [NPIN-1:0] chg_q
);

  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] chg_d;

  always_comb chg_d = (smp_i ^ prev_q) & ~dir_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      chg_q  <= '0;
    end else begin
      prev_q <= smp_i;
      chg_q  <= chg_d;
    end
  end

  // R7: a pulse never lasts two cycles while the sampled level holds still
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ((chg_q != '0) && (smp_i == prev_q)) |=> (chg_q == '0));

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_dp_pkg::*;
#(
  parameter int unsigned NPIN        = 8,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   dir_i,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   pin_o,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [NPIN-1:0]   acc_wdata,
  output logic [NPIN-1:0]   acc_rdata,
  output logic [NPIN-1:0]   data_o,
  output logic [NPIN-1:0]   in_chg_o
);

  acc_kind_e       kind;
  logic [NPIN-1:0] mask;
  logic [NPIN-1:0] smp;
  logic [NPIN-1:0] data_q;
  logic [NPIN-1:0] rdata_d;
  logic            rdata_en;

  gpio_win_decode #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_dec (
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr),
    .kind_o   (kind),
    .mask_o   (mask)
  );

  gpio_sync_chain #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (smp)
  );

  gpio_data_reg #(.NPIN(NPIN)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind_i  (kind),
    .mask_i  (mask),
    .wdata_i (acc_wdata),
    .dir_i   (dir_i),
    .smp_i   (smp),
    .data_q  (data_q)
  );

  gpio_chg_detect #(.NPIN(NPIN)) u_chg (
    .clk   (clk),
    .rst_n (rst_n),
    .smp_i (smp),
    .dir_i (dir_i),
    .chg_q (in_chg_o)
  );

  // Output pins drive their data bit, input pins float high.
  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pad
      assign pin_o[i] = dir_i[i] ? data_q[i] : 1'b1;
    end
  endgenerate

  assign data_o = data_q;

  // Registered read data with an explicit load enable.
  always_comb begin
    rdata_en = (kind == ACC_RD_HIT) || (kind == ACC_RD_MISS);
    rdata_d  = (kind == ACC_RD_HIT) ? (data_q & mask) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_rdata <= '0;
    else if (rdata_en) acc_rdata <= rdata_d;
  end

  // R2: bits outside the address mask read as zero
  a_r2_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_addr < ADDR_W'(4 << NPIN)) |=>
      ((acc_rdata & ~$past(mask)) == '0));

  // R8: a read outside the window returns zero
  a_r8_miss_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_addr >= ADDR_W'(4 << NPIN)) |=> (acc_rdata == '0));

  // R8: a write outside the window leaves the register alone
  a_r8_miss_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_addr >= ADDR_W'(4 << NPIN) && dir_i == '1) |=>
      $stable(data_o));

  // R2: without a read access the read data holds
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_wr) |=> $stable(acc_rdata));

endmodule

// File: tb/sim_gpio_masked_port.sv
module sim_gpio_masked_port;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  dir_i, pin_i, pin_o, acc_wdata, acc_rdata, data_o, in_chg_o;
  logic        acc_en, acc_wr;
  logic [11:0] acc_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Reference state, advanced once per rising edge.
  logic [7:0] m_s1, m_s2, m_prev, m_data, m_chg, m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_masked_port u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_i     (dir_i),
    .pin_i     (pin_i),
    .pin_o     (pin_o),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .data_o    (data_o),
    .in_chg_o  (in_chg_o)
  );

  function automatic logic [7:0] f_mask(logic [11:0] a);
    return a[9:2];
  endfunction

  function automatic bit f_hit(logic [11:0] a);
    return a[11:10] == 2'b00;
  endfunction

  function automatic logic [7:0] f_pin(logic [7:0] d, logic [7:0] dr);
    return (d & dr) | ~dr;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h at %0t", tag, got, exp, $time);
    end
  endtask

  // Called at a falling edge: compare, apply inputs, advance the model,
  // then wait for the next falling edge.
  task automatic cycle(input logic [7:0] dir, input logic [7:0] pin,
                       input bit en, input bit wr,
                       input logic [11:0] addr, input logic [7:0] wd);
    logic [7:0] n_data, n_rd, n_chg, wm;
    check("R3 R5 data_o", data_o, m_data);
    check("R4 pin_o", pin_o, f_pin(m_data, dir_i));
    check("R7 in_chg_o", in_chg_o, m_chg);
    check("R2 R8 acc_rdata", acc_rdata, m_rd);
    dir_i = dir; pin_i = pin; acc_en = en; acc_wr = wr;
    acc_addr = addr; acc_wdata = wd;
    n_data = (m_data & dir) | (m_s2 & ~dir);
    if (en && wr && f_hit(addr)) begin
      wm     = f_mask(addr) & dir;
      n_data = (n_data & ~wm) | (wd & wm);
    end
    n_rd = m_rd;
    if (en && !wr) n_rd = f_hit(addr) ? (m_data & f_mask(addr)) : 8'h00;
    n_chg  = (m_s2 ^ m_prev) & ~dir;
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = pin;
    m_data = n_data;
    m_rd   = n_rd;
    m_chg  = n_chg;
    @(negedge clk);
  endtask

  task automatic idle(input logic [7:0] dir, input logic [7:0] pin, input int n);
    for (int k = 0; k < n; k++) cycle(dir, pin, 1'b0, 1'b0, 12'h000, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; dir_i = 8'h00; pin_i = 8'h00; acc_en = 1'b0; acc_wr = 1'b0;
    acc_addr = '0; acc_wdata = '0;
    m_s1 = 0; m_s2 = 0; m_prev = 0; m_data = 0; m_chg = 0; m_rd = 0;
    r = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R6 reset state
    check("R6 data_o", data_o, 8'h00);
    check("R6 pin_o", pin_o, 8'hFF);
    check("R6 in_chg_o", in_chg_o, 8'h00);
    check("R6 acc_rdata", acc_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: full-mask write with all outputs
    cycle(8'hFF, 8'h00, 1'b1, 1'b1, 12'h3FC, 8'hA5);
    check("R3 full write", data_o, 8'hA5);
    check("R4 outputs drive data", pin_o, 8'hA5);
    // R1: mask from offset bits [9:2], low bits ignored -> mask 0x3C
    cycle(8'hFF, 8'h00, 1'b1, 1'b0, 12'h0F3, 8'h00);
    check("R1 masked read", acc_rdata, 8'h24);
    // R8: out-of-window write and read
    cycle(8'hFF, 8'h00, 1'b1, 1'b1, 12'h7FC, 8'h00);
    check("R8 write outside window", data_o, 8'hA5);
    cycle(8'hFF, 8'h00, 1'b1, 1'b0, 12'h7FC, 8'h00);
    check("R8 read outside window", acc_rdata, 8'h00);
    // R3: mask 0x0F with only upper nibble output -> no change
    cycle(8'hF0, 8'h00, 1'b1, 1'b1, 12'h03C, 8'h00);
    check("R3 input bits not written", data_o & 8'hF0, 8'hA0);
    // R3: single pin write, pin 7 via offset 0x200
    cycle(8'hF0, 8'h00, 1'b1, 1'b1, 12'h200, 8'h00);
    check("R3 single pin write", data_o & 8'hF0, 8'h20);
    // R5: input pins see 0x5A after three edges, output pins ignore pin_i
    cycle(8'hF0, 8'h5A, 1'b0, 1'b0, 12'h000, 8'h00);
    cycle(8'hF0, 8'h5A, 1'b0, 1'b0, 12'h000, 8'h00);
    check("R5 not yet after two edges", data_o & 8'h0F, 8'h00);
    cycle(8'hF0, 8'h5A, 1'b0, 1'b0, 12'h000, 8'h00);
    check("R5 input after three edges", data_o, 8'h2A);
    check("R7 change pulse", in_chg_o, 8'h0A);
    cycle(8'hF0, 8'h5A, 1'b0, 1'b0, 12'h000, 8'h00);
    check("R7 pulse one cycle", in_chg_o, 8'h00);
    check("R4 inputs float high", pin_o, 8'h2F);
    idle(8'h00, 8'h00, 4);

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0]  d, p, w;
      logic [11:0] a;
      bit          e, wr;
      d  = (n % 64 < 32) ? 8'h0F : 8'($urandom);
      p  = ($urandom % 4 == 0) ? 8'($urandom) : pin_i;
      e  = ($urandom % 3 != 0);
      wr = $urandom % 2;
      a  = ($urandom % 4 == 0) ? 12'($urandom) : {2'b00, 10'($urandom)};
      w  = 8'($urandom);
      cycle(d, p, e, wr, a, w);
    end
    idle(8'h00, 8'h00, 4);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule